// File: doc/BRIEF.md
# Serial Bit-Rate Clock Generator

This block produces the bit-rate timing for a synchronous serial port. It counts enable ticks that come from a 3.6864 MHz standard reference or, when selected, from an external clock. Both arrive as single-cycle ticks in the system clock domain. The selected ticks pass through a fixed divide-by-two prescaler. They then reach a programmable integer divider, so the serial bit rate runs from 1.8432 Mbps down to 7.2 kHz.

The block has two outputs. One is a single-cycle strobe for each bit period, which a shifter downstream uses as its bit-clock enable. The other is a serial clock level that changes state on every strobe. Clearing the port enable holds every counter at zero and silences both outputs. A new divide value written while the port runs is only picked up at the end of the current bit period.

Top module: `bitclk_gen`

## Requirements
- R1: When `use_ext` is 1, only `ext_tick` advances the counters and `ref_tick` is ignored. When `use_ext` is 0, the roles are swapped.
- R2: A fixed prescaler divides the selected tick stream by two. With `div_val` = 0, one strobe appears for every second selected tick.
- R3: With `div_val` = N, the bit period is 2*(N+1) selected ticks. This holds for the first period after enable and for every period after it.
- R4: `bit_stb` is high for exactly one system clock cycle. It rises in the cycle right after the system clock edge that sampled the tick completing the period.
- R5: While `enable` is 0, `bit_stb` stays 0 and `sclk` stays 0. The prescaler and divider counters are held at zero, so the first strobe after `enable` rises comes after exactly 2*(N+1) ticks.
- R6: A change of `div_val` during a running period does not alter that period. The new value sets the length of the period that starts at the next strobe.
- R7: `sclk` changes state on the same clock edge that raises `bit_stb`, and only then. Its first level after enable is 1.
- R8: The largest setting, `div_val` = 255, gives a period of 512 selected ticks, which is 7.2 kHz from the standard reference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle tick from the standard reference clock |
| ext_tick | input | 1 | One-cycle tick from the external clock |
| use_ext | input | 1 | 1 selects the external tick, 0 selects the reference tick |
| div_val | input | 8 | Divide value N; the divider divides by N+1 |
| enable | input | 1 | Port enable; 0 holds the counters and outputs at rest |
| bit_stb | output | 1 | One-cycle bit-clock enable strobe |
| sclk | output | 1 | Serial clock level that changes state on each strobe |

## Verification
The case that is hardest to reach from the ports is a change of the divide value in the middle of a running period. The latched value must survive until the terminal count, so the one period in flight keeps its old length. The bench reaches this by running with a short divide value and waiting for a strobe. It then sends two ticks, changes `div_val`, and measures the remaining length of that period and the length of the next one separately. It also disables the port part-way through a period. This shows that partial prescaler and divider counts are discarded and do not shorten the first period after the port is enabled again.

// File: rtl/bitclk_pkg.sv
`timescale 1ns/1ps
package bitclk_pkg;
   typedef enum logic {
      SRC_REF = 1'b0,
      SRC_EXT = 1'b1
   } clk_src_e;
endpackage

// File: rtl/bitclk_src_sel.sv
`timescale 1ns/1ps
module bitclk_src_sel #(
   parameter bit HAS_EXT = 1'b1
) (
   input  logic                  ref_tick,
   input  logic                  ext_tick,
   input  bitclk_pkg::clk_src_e  sel,
   output logic                  src_tick
);
   import bitclk_pkg::*;

   generate
      if (HAS_EXT) begin : g_mux
         assign src_tick = (sel == SRC_EXT) ? ext_tick : ref_tick;
      end else begin : g_ref_only
         logic unused_ext;
         assign unused_ext = ext_tick ^ sel;
         assign src_tick   = ref_tick;
      end
   endgenerate
endmodule

// File: rtl/bitclk_prescale.sv
`timescale 1ns/1ps
module bitclk_prescale #(
   parameter int unsigned PRE_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic src_tick,
   output logic pre_tick
);
   generate
      if (PRE_DIV < 1) begin : g_bad_pre
         $error("bitclk_prescale: PRE_DIV must be at least 1");
      end

      if (PRE_DIV == 1) begin : g_pass
         logic unused_ctl;
         assign unused_ctl = clk ^ rst_n;
         assign pre_tick   = run & src_tick;
      end else begin : g_count
         localparam int unsigned PW = $clog2(PRE_DIV);
         localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);
         logic [PW-1:0] cnt;
         logic          at_last;

         assign at_last = (cnt == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (!run) begin
               cnt <= '0;
            end else if (src_tick) begin
               cnt <= at_last ? '0 : cnt + 1'b1;
            end
         end

         assign pre_tick = run & src_tick & at_last;
      end
   endgenerate
endmodule

// File: rtl/bitclk_rate_div.sv
`timescale 1ns/1ps
module bitclk_rate_div #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             pre_tick,
   input  logic [DIV_W-1:0] div_val,
   output logic             term
);
   generate
      if (DIV_W < 1 || DIV_W > 24) begin : g_bad_w
         $error("bitclk_rate_div: DIV_W must lie in 1..24");
      end
   endgenerate

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] limit;
   logic             at_limit;

   assign at_limit = (cnt == limit);

   // The limit is captured only while idle or at terminal count, so a
   // mid-period write never stretches or cuts the running period.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         limit <= '0;
      end else if (!run) begin
         cnt   <= '0;
         limit <= div_val;
      end else if (pre_tick) begin
         if (at_limit) begin
            cnt   <= '0;
            limit <= div_val;
         end else begin
            cnt   <= cnt + 1'b1;
         end
      end
   end

   assign term = run & pre_tick & at_limit;
endmodule

// File: rtl/bitclk_gen.sv
`timescale 1ns/1ps
module bitclk_gen #(
   parameter int unsigned DIV_W   = 8,
   parameter int unsigned PRE_DIV = 2,
   parameter bit          HAS_EXT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_tick,
   input  logic             ext_tick,
   input  logic             use_ext,
   input  logic [DIV_W-1:0] div_val,
   input  logic             enable,
   output logic             bit_stb,
   output logic             sclk
);
   import bitclk_pkg::*;

   logic     src_tick;
   logic     pre_tick;
   logic     term;
   clk_src_e sel;

   assign sel = clk_src_e'(use_ext);

   bitclk_src_sel #(.HAS_EXT(HAS_EXT)) u_sel (
      .ref_tick (ref_tick),
      .ext_tick (ext_tick),
      .sel      (sel),
      .src_tick (src_tick)
   );

   bitclk_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (enable),
      .src_tick (src_tick),
      .pre_tick (pre_tick)
   );

   bitclk_rate_div #(.DIV_W(DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (enable),
      .pre_tick (pre_tick),
      .div_val  (div_val),
      .term     (term)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_stb <= 1'b0;
         sclk    <= 1'b0;
      end else if (!enable) begin
         bit_stb <= 1'b0;
         sclk    <= 1'b0;
      end else begin
         bit_stb <= term;
         sclk    <= sclk ^ term;
      end
   end
endmodule

// File: rtl/bitclk_chk.sv
`timescale 1ns/1ps
module bitclk_chk #(
   parameter int unsigned PRE_DIV = 2
) (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic use_ext,
   input logic ref_tick,
   input logic ext_tick,
   input logic bit_stb,
   input logic sclk
);
   // R5: a disabled port leaves both outputs at rest
   assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!bit_stb && !sclk));

   // R1: a cycle with no selected tick cannot produce a strobe
   assert_no_tick_no_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (use_ext ? !ext_tick : !ref_tick) |=> !bit_stb);

   // R7: each strobe comes with a change of serial clock level
   assert_sclk_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb |-> (sclk != $past(sclk)));

   // R7: without a strobe, a running serial clock keeps its level
   assert_sclk_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_stb && $past(enable)) |-> $stable(sclk));

   generate
      if (PRE_DIV > 1) begin : g_single
         // R4: the strobe never lasts two cycles
         assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
            bit_stb |=> !bit_stb);
      end
   endgenerate
endmodule

bind bitclk_gen bitclk_chk #(.PRE_DIV(PRE_DIV)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .enable   (enable),
   .use_ext  (use_ext),
   .ref_tick (ref_tick),
   .ext_tick (ext_tick),
   .bit_stb  (bit_stb),
   .sclk     (sclk)
);

// File: tb/sim_bitclk_gen.sv
`timescale 1ns/1ps
module sim_bitclk_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_tick = 1'b0;
   logic       ext_tick = 1'b0;
   logic       use_ext = 1'b0;
   logic [7:0] div_val = 8'd0;
   logic       enable = 1'b0;
   logic       bit_stb;
   logic       sclk;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   bitclk_gen u0 (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .ext_tick(ext_tick),
      .use_ext(use_ext), .div_val(div_val), .enable(enable),
      .bit_stb(bit_stb), .sclk(sclk)
   );

   typedef struct packed {
      logic       ext;
      logic [7:0] n;
   } vec_t;

   localparam int NVEC = 8;
   localparam vec_t VECS [NVEC] = '{
      '{1'b0, 8'd0}, '{1'b1, 8'd0}, '{1'b0, 8'd1}, '{1'b1, 8'd2},
      '{1'b0, 8'd5}, '{1'b1, 8'd17}, '{1'b0, 8'd100}, '{1'b1, 8'd255}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // One selected tick, then an idle cycle in which only the unselected
   // input pulses. The strobe for the tick is sampled one cycle later.
   task automatic send_tick(output logic saw);
      ref_tick = !use_ext;
      ext_tick = use_ext;
      @(negedge clk);
      saw = bit_stb;
      ref_tick = use_ext;
      ext_tick = !use_ext;
      @(negedge clk);
      check(bit_stb == 1'b0, "R4/R1 strobe outside tick", int'(bit_stb), 0);
      ref_tick = 1'b0;
      ext_tick = 1'b0;
   endtask

   task automatic ticks_to_pulse(input int limit, output int n);
      logic saw;
      n = 0;
      saw = 1'b0;
      while (!saw && n <= limit) begin
         send_tick(saw);
         n++;
      end
   endtask

   initial begin
      #(20ns * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int n;
      int exp;
      logic s0;
      logic saw;

      repeat (3) @(negedge clk);
      check(bit_stb == 1'b0 && sclk == 1'b0, "R5 reset state", int'({bit_stb, sclk}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk: R1, R2, R3, R7, R8
      for (int v = 0; v < NVEC; v++) begin
         enable  = 1'b0;
         use_ext = VECS[v].ext;
         div_val = VECS[v].n;
         @(negedge clk);
         enable = 1'b1;
         exp = 2 * (int'(VECS[v].n) + 1);
         ticks_to_pulse(exp + 2, n);
         check(n == exp, (VECS[v].n == 255) ? "R8 first period" :
               (VECS[v].n == 0) ? "R2 first period" : "R3 first period", n, exp);
         check(sclk == 1'b1, "R7 sclk after first strobe", int'(sclk), 1);
         ticks_to_pulse(exp + 2, n);
         check(n == exp, VECS[v].ext ? "R1 period with external source" : "R3 second period", n, exp);
         check(sclk == 1'b0, "R7 sclk after second strobe", int'(sclk), 0);
      end

      // R5: disabled port ignores ticks
      enable  = 1'b0;
      use_ext = 1'b0;
      div_val = 8'd0;
      @(negedge clk);
      n = 0;
      for (int i = 0; i < 20; i++) begin
         send_tick(saw);
         if (saw) n++;
      end
      check(n == 0, "R5 no strobe while disabled", n, 0);
      check(sclk == 1'b0, "R5 sclk rests low", int'(sclk), 0);

      // R5: partial counts are cleared by disable
      div_val = 8'd1;
      enable  = 1'b1;
      for (int i = 0; i < 3; i++) send_tick(saw);
      enable = 1'b0;
      repeat (2) @(negedge clk);
      enable = 1'b1;
      ticks_to_pulse(10, n);
      check(n == 4, "R5 restart after disable", n, 4);

      // R6: mid-period divide change waits for the terminal count
      enable  = 1'b0;
      div_val = 8'd3;
      @(negedge clk);
      enable = 1'b1;
      ticks_to_pulse(12, n);
      check(n == 8, "R6 first period at N=3", n, 8);
      send_tick(saw);
      send_tick(saw);
      div_val = 8'd9;
      ticks_to_pulse(12, n);
      check(n + 2 == 8, "R6 running period keeps old value", n + 2, 8);
      ticks_to_pulse(24, n);
      check(n == 20, "R6 next period uses new value", n, 20);

      // R4/R7: strobe width and sclk level on one strobe
      s0 = sclk;
      ticks_to_pulse(24, n);
      check(sclk == !s0, "R7 sclk toggles on strobe", int'(sclk), int'(!s0));
      @(negedge clk);
      check(bit_stb == 1'b0, "R4 single-cycle strobe", int'(bit_stb), 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule